// File: doc/BRIEF.md
# Tagged Register File with Run-Time Checks

This block is a 256-entry register file in which every entry carries a 64-bit payload together with a 4-bit type tag and a 4-bit provenance field. Two read ports and one write port are each addressed by an 8-bit index. The write port performs one operation per cycle: a full word write, a tag-only load, or a tag-read that turns the tag of a source register into a payload.

The reads are combinational. The block raises a coded exception request in the same cycle whenever an enabled read touches a register that has never been given a type, or when a tag comparison on port A fails. For each of the three index ports, the block also reports which of the four fixed regions the index falls in. The regions are input, output, internal and temporary, with 64 entries each.

All pins are plain control and data pins with no handshake. The surrounding datapath presents one operation per cycle and must accept the read results and the exception request in that same cycle. There is no back-pressure in either direction.

Top module: `tagged_regfile`

## Requirements
- R1: After reset every entry holds payload 0, tag 0xF (uninitialized) and provenance 0xF (unset). Tag encodings: 0x0 boolean, 0x1 unsigned, 0x2 signed, 0xF uninitialized. Provenance encodings: 0x0 input port, 0x1 computed, 0x2 literal, 0xF unset.
- R2: When `wr_op` is 1 (word write), the entry at `wr_idx` takes `wr_data`, `wr_tag` and `wr_prov`. Both read ports show the new word from the cycle after the clock edge.
- R3: Reads are combinational. When a register is read and written in the same cycle, the read returns the value held before the edge.
- R4: When `wr_op` is 2 (tag load), only the tag of the entry at `wr_idx` is replaced by `wr_tag`. Its payload and provenance stay unchanged.
- R5: When `wr_op` is 3 (tag read), the entry at `wr_idx` receives the tag of the entry addressed by `rd_a_idx`, zero-extended to 64 bits, with tag 0x1 (unsigned) and provenance 0x1 (computed). This operation raises no exception even when the source is uninitialized.
- R6: If an enabled read port (`rd_a_en` or `rd_b_en`) addresses an entry whose tag is 0xF, `exc_valid` is high and `exc_code` is 2 in that same cycle. A check on port A (`chk_en`) counts as a read of port A.
- R7: When `chk_en` is high and the port A tag differs from `chk_tag`, `exc_valid` is high with `exc_code` 3, unless R6 applies, in which case code 2 wins. With no exception, `exc_valid` is low and `exc_code` is 0.
- R8: `rd_a_region`, `rd_b_region` and `wr_region` give the region of their index as the top two index bits: 0 for input (0–63), 1 for output (64–127), 2 for internal (128–191), 3 for temporary (192–255).
- R9: When `wr_op` is 0 (none), no entry changes, whatever the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_op | input | 2 | Write operation: 0 none, 1 word write, 2 tag load, 3 tag read |
| wr_idx | input | 8 | Destination index |
| wr_data | input | 64 | Payload for word write |
| wr_tag | input | 4 | Tag for word write or tag load |
| wr_prov | input | 4 | Provenance for word write |
| rd_a_en | input | 1 | Port A read is used (enables uninitialized check) |
| rd_a_idx | input | 8 | Port A index; also the tag-read source |
| rd_a_data | output | 64 | Port A payload |
| rd_a_tag | output | 4 | Port A tag |
| rd_a_prov | output | 4 | Port A provenance |
| rd_b_en | input | 1 | Port B read is used |
| rd_b_idx | input | 8 | Port B index |
| rd_b_data | output | 64 | Port B payload |
| rd_b_tag | output | 4 | Port B tag |
| rd_b_prov | output | 4 | Port B provenance |
| chk_en | input | 1 | Compare the port A tag with `chk_tag` |
| chk_tag | input | 4 | Expected tag |
| exc_valid | output | 1 | Exception request |
| exc_code | output | 4 | Exception code (2 uninitialized, 3 mismatch, 0 none) |
| rd_a_region | output | 2 | Region of `rd_a_idx` |
| rd_b_region | output | 2 | Region of `rd_b_idx` |
| wr_region | output | 2 | Region of `wr_idx` |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a write and a read of the same register. The bench points port A at a register while a word write to it is pending. It then samples before the edge, expecting the old word, and after the edge, expecting the new one. The second pair is the two exception causes. The bench issues a tag check against an uninitialized register whose expected tag also mismatches, and judges that code 2 is reported and not code 3.

// File: rtl/tagrf_pkg.sv
package tagrf_pkg;
  localparam int DATA_W   = 64;
  localparam int TAG_W    = 4;
  localparam int PROV_W   = 4;
  localparam int IDX_W    = 8;
  localparam int REGION_W = 2;
  localparam int EXC_W    = 4;
  localparam int N_ENTRY  = 1 << IDX_W;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_TAG_LD  = 2'd2,
    OP_TAG_RD  = 2'd3
  } wr_op_e;

  localparam logic [TAG_W-1:0]  TAG_BOOL   = 4'h0;
  localparam logic [TAG_W-1:0]  TAG_UNS    = 4'h1;
  localparam logic [TAG_W-1:0]  TAG_SGN    = 4'h2;
  localparam logic [TAG_W-1:0]  TAG_UNINIT = 4'hF;

  localparam logic [PROV_W-1:0] PROV_PORT  = 4'h0;
  localparam logic [PROV_W-1:0] PROV_CALC  = 4'h1;
  localparam logic [PROV_W-1:0] PROV_IMM   = 4'h2;
  localparam logic [PROV_W-1:0] PROV_UNSET = 4'hF;

  localparam logic [EXC_W-1:0]  EXC_NONE     = 4'd0;
  localparam logic [EXC_W-1:0]  EXC_UNINIT   = 4'd2;
  localparam logic [EXC_W-1:0]  EXC_MISMATCH = 4'd3;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [TAG_W-1:0]  tag;
    logic [PROV_W-1:0] prov;
  } word_t;

  localparam word_t WORD_RESET = '{data: '0, tag: TAG_UNINIT, prov: PROV_UNSET};
endpackage

// File: rtl/tagrf_region.sv
module tagrf_region
  import tagrf_pkg::*;
#(
  parameter int N_PORTS = 3
) (
  input  logic [N_PORTS-1:0][IDX_W-1:0]    idx,
  output logic [N_PORTS-1:0][REGION_W-1:0] region
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    // the region is the upper bits of the index: equal-sized fixed partitions
    assign region[p] = idx[p][IDX_W-1 -: REGION_W];
  end
endmodule

// File: rtl/tagrf_store.sv
module tagrf_store
  import tagrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  wr_op_e           op,
  input  logic [IDX_W-1:0] w_idx,
  input  word_t            w_word,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [IDX_W-1:0] b_idx,
  output word_t            a_word,
  output word_t            b_word
);
  word_t mem [N_ENTRY];
  word_t next_word;

  assign a_word = mem[a_idx];
  assign b_word = mem[b_idx];

  // the tag-read source is port A, read before the edge
  always_comb begin
    next_word = mem[w_idx];
    unique case (op)
      OP_WRITE:  next_word = w_word;
      OP_TAG_LD: next_word.tag = w_word.tag;
      OP_TAG_RD: begin
        next_word.data = {{(DATA_W-TAG_W){1'b0}}, a_word.tag};
        next_word.tag  = TAG_UNS;
        next_word.prov = PROV_CALC;
      end
      default:   next_word = mem[w_idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRY; i++) mem[i] <= WORD_RESET;
    end else if (op != OP_NONE) begin
      mem[w_idx] <= next_word;
    end
  end
endmodule

// File: rtl/tagrf_exc.sv
module tagrf_exc
  import tagrf_pkg::*;
(
  input  logic             a_en,
  input  logic [TAG_W-1:0] a_tag,
  input  logic             b_en,
  input  logic [TAG_W-1:0] b_tag,
  input  logic             chk_en,
  input  logic [TAG_W-1:0] chk_tag,
  output logic             valid,
  output logic [EXC_W-1:0] code
);
  logic a_used, uninit_hit, mismatch;

  assign a_used     = a_en | chk_en;
  assign uninit_hit = (a_used && a_tag == TAG_UNINIT) || (b_en && b_tag == TAG_UNINIT);
  assign mismatch   = chk_en && (a_tag != chk_tag);

  always_comb begin
    valid = 1'b0;
    code  = EXC_NONE;
    if (uninit_hit) begin
      valid = 1'b1;
      code  = EXC_UNINIT;
    end else if (mismatch) begin
      valid = 1'b1;
      code  = EXC_MISMATCH;
    end
  end
endmodule

// File: rtl/tagged_regfile.sv
module tagged_regfile
  import tagrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr_op,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PROV_W-1:0] wr_prov,
  input  logic              rd_a_en,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [PROV_W-1:0] rd_a_prov,
  input  logic              rd_b_en,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [TAG_W-1:0]  rd_b_tag,
  output logic [PROV_W-1:0] rd_b_prov,
  input  logic              chk_en,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              exc_valid,
  output logic [EXC_W-1:0]  exc_code,
  output logic [REGION_W-1:0] rd_a_region,
  output logic [REGION_W-1:0] rd_b_region,
  output logic [REGION_W-1:0] wr_region
);
  localparam int N_IDX_PORTS = 3;

  word_t w_word, a_word, b_word;
  logic [N_IDX_PORTS-1:0][IDX_W-1:0]    idx_vec;
  logic [N_IDX_PORTS-1:0][REGION_W-1:0] reg_vec;

  assign w_word = '{data: wr_data, tag: wr_tag, prov: wr_prov};

  tagrf_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (wr_op_e'(wr_op)),
    .w_idx  (wr_idx),
    .w_word (w_word),
    .a_idx  (rd_a_idx),
    .b_idx  (rd_b_idx),
    .a_word (a_word),
    .b_word (b_word)
  );

  assign rd_a_data = a_word.data;
  assign rd_a_tag  = a_word.tag;
  assign rd_a_prov = a_word.prov;
  assign rd_b_data = b_word.data;
  assign rd_b_tag  = b_word.tag;
  assign rd_b_prov = b_word.prov;

  tagrf_exc u_exc (
    .a_en    (rd_a_en),
    .a_tag   (a_word.tag),
    .b_en    (rd_b_en),
    .b_tag   (b_word.tag),
    .chk_en  (chk_en),
    .chk_tag (chk_tag),
    .valid   (exc_valid),
    .code    (exc_code)
  );

  assign idx_vec = {wr_idx, rd_b_idx, rd_a_idx};

  tagrf_region #(.N_PORTS(N_IDX_PORTS)) u_region (
    .idx    (idx_vec),
    .region (reg_vec)
  );

  assign rd_a_region = reg_vec[0];
  assign rd_b_region = reg_vec[1];
  assign wr_region   = reg_vec[2];
endmodule

// File: rtl/tagged_regfile_chk.sv
module tagged_regfile_chk
  import tagrf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        wr_op,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [TAG_W-1:0]  wr_tag,
  input logic              rd_a_en,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [TAG_W-1:0]  rd_a_tag,
  input logic [PROV_W-1:0] rd_a_prov,
  input logic              rd_b_en,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [TAG_W-1:0]  rd_b_tag,
  input logic [PROV_W-1:0] rd_b_prov,
  input logic              chk_en,
  input logic [TAG_W-1:0]  chk_tag,
  input logic              exc_valid,
  input logic [EXC_W-1:0]  exc_code
);
  // R2: a word write is visible on port A one cycle later
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_WRITE) |=>
      (rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data) && rd_a_tag == $past(wr_tag)));

  // R4: tag load keeps payload and provenance
  a_r4_tag_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_TAG_LD && rd_a_idx == wr_idx) |=>
      (!$stable(rd_a_idx)) ||
      (rd_a_data == $past(rd_a_data) && rd_a_prov == $past(rd_a_prov) && rd_a_tag == $past(wr_tag)));

  // R5: a tag-read result is marked unsigned and computed
  a_r5_tag_read_meta: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_TAG_RD && rd_b_idx == wr_idx) |=>
      (!$stable(rd_b_idx)) || (rd_b_tag == TAG_UNS && rd_b_prov == PROV_CALC));

  // R6: uninitialized read on either port
  a_r6_uninit_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_en && rd_a_tag == TAG_UNINIT) |-> (exc_valid && exc_code == EXC_UNINIT));
  a_r6_uninit_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_en && rd_b_tag == TAG_UNINIT) |-> (exc_valid && exc_code == EXC_UNINIT));

  // R7: mismatch reported when no uninitialized read is present
  a_r7_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && rd_a_tag != TAG_UNINIT && rd_a_tag != chk_tag &&
     !(rd_b_en && rd_b_tag == TAG_UNINIT)) |-> (exc_valid && exc_code == EXC_MISMATCH));
  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid ? (exc_code == EXC_UNINIT || exc_code == EXC_MISMATCH) : (exc_code == EXC_NONE));

  // R9: no operation leaves the addressed word untouched
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_NONE) |=>
      (!$stable(rd_a_idx)) || ($stable(rd_a_data) && $stable(rd_a_tag) && $stable(rd_a_prov)));
endmodule

bind tagged_regfile tagged_regfile_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_op(wr_op), .wr_idx(wr_idx), .wr_data(wr_data),
  .wr_tag(wr_tag), .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_a_tag(rd_a_tag), .rd_a_prov(rd_a_prov), .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx),
  .rd_b_tag(rd_b_tag), .rd_b_prov(rd_b_prov), .chk_en(chk_en), .chk_tag(chk_tag),
  .exc_valid(exc_valid), .exc_code(exc_code)
);

// File: tb/test_tagged_regfile.sv
`timescale 1ns/1ps
module test_tagged_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  wr_op = 2'd0;
  logic [7:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  wr_tag = '0;
  logic [3:0]  wr_prov = '0;
  logic        rd_a_en = 1'b0;
  logic [7:0]  rd_a_idx = '0;
  logic [63:0] rd_a_data;
  logic [3:0]  rd_a_tag, rd_a_prov;
  logic        rd_b_en = 1'b0;
  logic [7:0]  rd_b_idx = '0;
  logic [63:0] rd_b_data;
  logic [3:0]  rd_b_tag, rd_b_prov;
  logic        chk_en = 1'b0;
  logic [3:0]  chk_tag = '0;
  logic        exc_valid;
  logic [3:0]  exc_code;
  logic [1:0]  rd_a_region, rd_b_region, wr_region;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tagged_regfile i_tagged_regfile (
    .clk(clk), .rst_n(rst_n), .wr_op(wr_op), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_tag(wr_tag), .wr_prov(wr_prov), .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx),
    .rd_a_data(rd_a_data), .rd_a_tag(rd_a_tag), .rd_a_prov(rd_a_prov),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_tag(rd_b_tag),
    .rd_b_prov(rd_b_prov), .chk_en(chk_en), .chk_tag(chk_tag), .exc_valid(exc_valid),
    .exc_code(exc_code), .rd_a_region(rd_a_region), .rd_b_region(rd_b_region),
    .wr_region(wr_region)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  idx;
    logic [63:0] data;
    logic [3:0]  tag;
    logic [3:0]  prov;
    logic [7:0]  src;
    logic [63:0] e_data;
    logic [3:0]  e_tag;
    logic [3:0]  e_prov;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'd5,   64'h1234,               4'h1, 4'h0, 8'd0,   64'h1234,               4'h1, 4'h0},
    '{2'd1, 8'd200, 64'hFFFF_FFFF_FFFF_FFFF, 4'h2, 4'h2, 8'd0,   64'hFFFF_FFFF_FFFF_FFFF, 4'h2, 4'h2},
    '{2'd2, 8'd5,   64'hDEAD,               4'h0, 4'h7, 8'd0,   64'h1234,               4'h0, 4'h0},
    '{2'd3, 8'd70,  64'hBEEF,               4'h0, 4'h0, 8'd200, 64'h2,                  4'h1, 4'h1},
    '{2'd3, 8'd130, 64'h0,                  4'h0, 4'h0, 8'd99,  64'hF,                  4'h1, 4'h1},
    '{2'd1, 8'd255, 64'hA5,                 4'h0, 4'h1, 8'd0,   64'hA5,                 4'h0, 4'h1},
    '{2'd2, 8'd64,  64'h77,                 4'h2, 4'h0, 8'd0,   64'h0,                  4'h2, 4'hF},
    '{2'd0, 8'd5,   64'h9999,               4'h2, 4'h2, 8'd0,   64'h1234,               4'h0, 4'h0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_op = 2'd0; rd_a_en = 1'b0; rd_b_en = 1'b0; chk_en = 1'b0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state on both ports
    rd_a_idx = 8'd0; rd_b_idx = 8'd255; #1;
    check("R1 data a", rd_a_data, 64'h0);
    check("R1 tag a", rd_a_tag, 4'hF);
    check("R1 prov b", rd_b_prov, 4'hF);
    check("R1 tag b", rd_b_tag, 4'hF);

    // R6: enabled read of an uninitialized entry, port B only
    rd_b_en = 1'b1; rd_b_idx = 8'd131; #1;
    check("R6 valid b", exc_valid, 1);
    check("R6 code b", exc_code, 2);
    rd_b_en = 1'b0; #1;
    check("R7 no exc code", exc_code, 0);

    // table of operations, each read back on port A one cycle later
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_op = VECS[v].op; wr_idx = VECS[v].idx; wr_data = VECS[v].data;
      wr_tag = VECS[v].tag; wr_prov = VECS[v].prov; rd_a_idx = VECS[v].src;
      #1;
      if (VECS[v].op == 2'd3) check("R5 no exc on tag read", exc_valid, 0);
      @(posedge clk); #1;
      idle(); rd_a_idx = VECS[v].idx; #1;
      check("R2 R4 R5 R9 data", rd_a_data, VECS[v].e_data);
      check("R2 R4 R5 R9 tag", rd_a_tag, VECS[v].e_tag);
      check("R2 R4 R5 R9 prov", rd_a_prov, VECS[v].e_prov);
    end

    // R7: tag check match and mismatch on entry 5 (tag boolean)
    @(negedge clk);
    rd_a_idx = 8'd5; chk_en = 1'b1; chk_tag = 4'h0; #1;
    check("R7 match", exc_valid, 0);
    chk_tag = 4'h1; #1;
    check("R7 mismatch valid", exc_valid, 1);
    check("R7 mismatch code", exc_code, 3);
    // R7: uninitialized entry with a wrong expected tag reports code 2
    rd_a_idx = 8'd10; chk_tag = 4'h2; #1;
    check("R7 priority code", exc_code, 2);
    chk_en = 1'b0;

    // R3: same-cycle read and write returns the old word
    @(negedge clk);
    rd_a_idx = 8'd5; wr_op = 2'd1; wr_idx = 8'd5; wr_data = 64'hCAFE;
    wr_tag = 4'h2; wr_prov = 4'h2; #1;
    check("R3 old data", rd_a_data, 64'h1234);
    @(posedge clk); #1;
    idle(); #1;
    check("R3 new data", rd_a_data, 64'hCAFE);

    // R8: region boundaries on all three index ports
    rd_a_idx = 8'd63; rd_b_idx = 8'd64; wr_idx = 8'd127; #1;
    check("R8 a 63", rd_a_region, 0);
    check("R8 b 64", rd_b_region, 1);
    check("R8 w 127", wr_region, 1);
    rd_a_idx = 8'd128; rd_b_idx = 8'd191; wr_idx = 8'd192; #1;
    check("R8 a 128", rd_a_region, 2);
    check("R8 b 191", rd_b_region, 2);
    check("R8 w 192", wr_region, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule